// File: doc/BRIEF.md
# Palette-Indexed Scan-Line Pixel Unpacker

This block turns a stream of 16-bit framebuffer words into 24-bit RGB pixels for one scan line. Each line starts with a `line_start` pulse. The pulse latches the pixel depth, the colour-format flag and the pixel count for that line. The depth is not set by a register. It comes from a 3-bit code held in bits 14:12 of palette entry 0, so software selects the depth by writing that entry.

At 2, 4 and 8 bits per pixel, each pixel is an index into a palette RAM of 256 entries by 16 bits. At 16 bits per pixel, the word is itself the colour. It is read as 5-6-5 when the format flag is set, and as 4-4-4 in its low 12 bits when the flag is clear.

Words arrive on a valid/ready input. Pixels leave on a valid/ready output that marks the last pixel of the line. Words and pixels are both released as soon as the other side is ready, so either side may stall the flow.

Top module: `pal_line_unpacker`

## Requirements
- R1: At `line_start`, the depth code is taken from bits 14:12 of palette entry 0. Code 1 selects 2 bpp (8 pixels per word), code 2 selects 4 bpp (4 per word), code 3 selects 8 bpp (2 per word), and codes 4 to 7 select 16 bpp (1 per word). Writes to entry 0 during a line do not change that line's depth.
- R2: When the latched code is 0 or the latched width is 0, the line produces no pixels and accepts no words: `pix_valid` and `word_ready` stay low until the next `line_start`.
- R3: At 2, 4 and 8 bpp, pixel k of a word uses the index held in word bits [k*bpp + bpp-1 : k*bpp], so the least significant field comes first. The index is looked up in the palette. Bits 11:0 of the entry are read as R[11:8], G[7:4], B[3:0], and each 4-bit field becomes an 8-bit field by repeating the nibble.
- R4: At 16 bpp with the format flag set, the word is read as R[15:11], G[10:5], B[4:0]. Each field is widened to 8 bits by copying its top bits into its low bits.
- R5: At 16 bpp with the format flag clear, bits 11:0 of the word are expanded as 4-4-4 in the same way as palette entries.
- R6: A line yields exactly `width` pixels. `pix_eol` is high on the last of them only. After that pixel is taken, the block is idle.
- R7: A line consumes exactly ceil(width*bpp/16) words. Any pixel fields left over in the last word are dropped.
- R8: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_rgb` and `pix_eol` hold their values. This holds as long as no `line_start` arrives and, for `pix_rgb`, no palette write changes the entry being shown.
- R9: After reset, `pix_valid` and `word_ready` are low and the latched depth code is 0.
- R10: `word_ready` is high only when no word is held, and `pix_valid` is high only while a word is held. A word accepted at a clock edge presents its first pixel in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pal_we | input | 1 | Palette write strobe |
| pal_addr | input | 8 | Palette write address |
| pal_wdata | input | 16 | Palette write data (entry 0 bits 14:12 = depth code) |
| tft_i | input | 1 | 16 bpp format: 1 = 5-6-5, 0 = 4-4-4 |
| width_i | input | 10 | Pixels in the line |
| line_start | input | 1 | Starts a line and latches the mode and width |
| word_valid | input | 1 | Framebuffer word valid |
| word_ready | output | 1 | Block accepts a word |
| word_data | input | 16 | Framebuffer word |
| pix_valid | output | 1 | Pixel valid |
| pix_ready | input | 1 | Sink takes the pixel |
| pix_rgb | output | 24 | Pixel colour, R in 23:16, G in 15:8, B in 7:0 |
| pix_eol | output | 1 | Last pixel of the line |

## Verification
The block has one register stage between the word input and the pixel output. `word_ready` rises in the cycle after `line_start`. The first pixel of a word is valid in the cycle after the word handshake, and its colour and end-of-line flag are combinational from the held word in that same cycle. After the end-of-line pixel is taken, both `word_ready` and `pix_valid` are low in the next cycle.

The bench changes inputs on the falling edge and reads every handshake one nanosecond before the rising edge, so each result is checked in the cycle where it is due. After a stalled pixel, the next sample must show the same values. After each accepted word, the next sample must show `pix_valid` high. Each line runs five more cycles after its end, to show that no extra word or pixel passes.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

   typedef enum logic [1:0] {
      DEPTH_2  = 2'd0,
      DEPTH_4  = 2'd1,
      DEPTH_8  = 2'd2,
      DEPTH_16 = 2'd3
   } depth_e;

   localparam int CODE_W = 3;

   function automatic depth_e code_to_depth(input logic [CODE_W-1:0] code);
      case (code)
         3'd1:    return DEPTH_2;
         3'd2:    return DEPTH_4;
         3'd3:    return DEPTH_8;
         default: return DEPTH_16;
      endcase
   endfunction

endpackage

// File: rtl/unpack_pal_ram.sv
module unpack_pal_ram
   import unpack_pkg::*;
#(
   parameter int ENTRIES  = 256,
   parameter int DATA_W   = 16,
   parameter int CODE_LSB = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [$clog2(ENTRIES)-1:0] waddr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [$clog2(ENTRIES)-1:0] raddr,
   output logic [DATA_W-1:0]          rdata,
   output logic [CODE_W-1:0]          mode_code
);
   localparam int ADDR_W = $clog2(ENTRIES);

   generate
      if (CODE_LSB + CODE_W > DATA_W) begin : g_bad_code
         $error("depth code does not fit in a palette entry");
      end
   endgenerate

   logic [DATA_W-1:0] mem [ENTRIES];
   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // shadow of the depth field of entry 0, reset to the invalid code
   always_ff @(posedge clk) begin
      if (!rst_n)                          code_q <= '0;
      else if (we && waddr == ADDR_W'(0))  code_q <= wdata[CODE_LSB +: CODE_W];
   end

   assign rdata     = mem[raddr];
   assign mode_code = code_q;

endmodule

// File: rtl/unpack_slot_sel.sv
module unpack_slot_sel
   import unpack_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int IDX_W  = 8,
   parameter int SLOT_W = 3
) (
   input  logic [WORD_W-1:0] word,
   input  logic [SLOT_W-1:0] slot,
   input  depth_e            depth,
   output logic [IDX_W-1:0]  idx
);
   logic [WORD_W-1:0] shifted;

   always_comb begin
      case (depth)
         DEPTH_2: shifted = (word >> {slot, 1'b0})  & WORD_W'(8'h03);
         DEPTH_4: shifted = (word >> {slot, 2'b00}) & WORD_W'(8'h0f);
         DEPTH_8: shifted = (word >> {slot, 3'b000}) & WORD_W'(8'hff);
         default: shifted = word;
      endcase
      idx = shifted[IDX_W-1:0];
   end

endmodule

// File: rtl/unpack_colour.sv
module unpack_colour
   import unpack_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int RGB_W  = 24
) (
   input  depth_e            depth,
   input  logic              tft,
   input  logic [WORD_W-1:0] word,
   input  logic [WORD_W-1:0] pal_entry,
   output logic [RGB_W-1:0]  rgb
);
   localparam int CH_W  = RGB_W / 3;
   localparam int NIB_W = 4;

   generate
      if (CH_W != 8 || RGB_W % 3 != 0) begin : g_bad_rgb
         $error("RGB_W must be three 8-bit channels");
      end
   endgenerate

   logic [3*NIB_W-1:0] src12;
   logic [RGB_W-1:0]   rgb444;
   logic [RGB_W-1:0]   rgb565;

   assign src12 = (depth == DEPTH_16) ? word[3*NIB_W-1:0] : pal_entry[3*NIB_W-1:0];

   genvar ch;
   generate
      for (ch = 0; ch < 3; ch++) begin : g_ch
         assign rgb444[ch*CH_W +: CH_W] = {src12[ch*NIB_W +: NIB_W], src12[ch*NIB_W +: NIB_W]};
      end
   endgenerate

   assign rgb565 = {word[15:11], word[15:13], word[10:5], word[10:9], word[4:0], word[4:2]};

   assign rgb = (depth == DEPTH_16 && tft) ? rgb565 : rgb444;

endmodule

// File: rtl/pal_line_unpacker.sv
module pal_line_unpacker
   import unpack_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int PAL_ENTRIES = 256,
   parameter int WIDTH_W     = 10,
   parameter int RGB_W       = 24
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           pal_we,
   input  logic [$clog2(PAL_ENTRIES)-1:0] pal_addr,
   input  logic [WORD_W-1:0]              pal_wdata,
   input  logic                           tft_i,
   input  logic [WIDTH_W-1:0]             width_i,
   input  logic                           line_start,
   input  logic                           word_valid,
   output logic                           word_ready,
   input  logic [WORD_W-1:0]              word_data,
   output logic                           pix_valid,
   input  logic                           pix_ready,
   output logic [RGB_W-1:0]               pix_rgb,
   output logic                           pix_eol
);
   localparam int IDX_W  = $clog2(PAL_ENTRIES);
   localparam int SLOT_W = $clog2(WORD_W / 2);

   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("WORD_W must be 16");
      end
      if (IDX_W != 8) begin : g_bad_pal
         $error("palette must hold 256 entries");
      end
      if (WIDTH_W < 1 || WIDTH_W > 16) begin : g_bad_width
         $error("WIDTH_W out of range");
      end
   endgenerate

   logic [CODE_W-1:0]  mode_code;
   logic [WORD_W-1:0]  pal_rdata;
   logic [IDX_W-1:0]   idx;

   logic               busy_q, have_q, tft_q;
   depth_e             depth_q;
   logic [WORD_W-1:0]  word_q;
   logic [SLOT_W-1:0]  slot_q;
   logic [WIDTH_W-1:0] cnt_q, width_q;
   logic [SLOT_W-1:0]  slot_last;
   logic               word_fire, pix_fire, line_ok;

   unpack_pal_ram #(.ENTRIES(PAL_ENTRIES), .DATA_W(WORD_W), .CODE_LSB(12)) u_pal (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (pal_we),
      .waddr    (pal_addr),
      .wdata    (pal_wdata),
      .raddr    (idx),
      .rdata    (pal_rdata),
      .mode_code(mode_code)
   );

   unpack_slot_sel #(.WORD_W(WORD_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_sel (
      .word (word_q),
      .slot (slot_q),
      .depth(depth_q),
      .idx  (idx)
   );

   unpack_colour #(.WORD_W(WORD_W), .RGB_W(RGB_W)) u_col (
      .depth    (depth_q),
      .tft      (tft_q),
      .word     (word_q),
      .pal_entry(pal_rdata),
      .rgb      (pix_rgb)
   );

   always_comb begin
      case (depth_q)
         DEPTH_2: slot_last = SLOT_W'(WORD_W / 2 - 1);
         DEPTH_4: slot_last = SLOT_W'(WORD_W / 4 - 1);
         DEPTH_8: slot_last = SLOT_W'(WORD_W / 8 - 1);
         default: slot_last = '0;
      endcase
   end

   assign line_ok    = (mode_code != '0) && (width_i != '0);
   assign word_ready = busy_q && !have_q && !line_start;
   assign pix_valid  = busy_q && have_q;
   assign pix_eol    = pix_valid && (cnt_q == width_q);
   assign word_fire  = word_valid && word_ready;
   assign pix_fire   = pix_valid && pix_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         have_q  <= 1'b0;
         tft_q   <= 1'b0;
         depth_q <= DEPTH_16;
         word_q  <= '0;
         slot_q  <= '0;
         cnt_q   <= '0;
         width_q <= '0;
      end else if (line_start) begin
         busy_q  <= line_ok;
         have_q  <= 1'b0;
         slot_q  <= '0;
         cnt_q   <= WIDTH_W'(1);
         depth_q <= code_to_depth(mode_code);
         tft_q   <= tft_i;
         width_q <= width_i;
      end else begin
         if (word_fire) begin
            word_q <= word_data;
            have_q <= 1'b1;
            slot_q <= '0;
         end
         if (pix_fire) begin
            cnt_q <= cnt_q + WIDTH_W'(1);
            if (pix_eol) begin
               busy_q <= 1'b0;
               have_q <= 1'b0;
            end else if (slot_q == slot_last) begin
               have_q <= 1'b0;
            end else begin
               slot_q <= slot_q + SLOT_W'(1);
            end
         end
      end
   end

   // R2
   no_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_start && !line_ok |=> !word_ready && !pix_valid);

   // R10
   ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(word_ready && pix_valid));

   // R10
   accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid && word_ready |=> pix_valid);

   // R6
   eol_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && pix_ready && pix_eol && !line_start |=> !pix_valid && !word_ready);

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && !pix_ready && !line_start && !pal_we
      |=> pix_valid && $stable(pix_rgb) && $stable(pix_eol));

endmodule

// File: tb/pal_line_unpacker_test.sv
module pal_line_unpacker_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pal_we = 1'b0;
   logic [7:0]  pal_addr = '0;
   logic [15:0] pal_wdata = '0;
   logic        tft_i = 1'b0;
   logic [9:0]  width_i = '0;
   logic        line_start = 1'b0;
   logic        word_valid = 1'b0;
   logic        word_ready;
   logic [15:0] word_data = '0;
   logic        pix_valid;
   logic        pix_ready = 1'b0;
   logic [23:0] pix_rgb;
   logic        pix_eol;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   logic [15:0] pal_m [256];

   pal_line_unpacker uut (
      .clk(clk), .rst_n(rst_n), .pal_we(pal_we), .pal_addr(pal_addr),
      .pal_wdata(pal_wdata), .tft_i(tft_i), .width_i(width_i),
      .line_start(line_start), .word_valid(word_valid), .word_ready(word_ready),
      .word_data(word_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
      .pix_rgb(pix_rgb), .pix_eol(pix_eol)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] wordf(input int seed, input int k);
      return 16'((k * 28469 + seed * 7919) ^ 16'hA7C1 ^ (k << 9));
   endfunction

   function automatic logic [23:0] exp444(input logic [11:0] v);
      return {v[11:8], v[11:8], v[7:4], v[7:4], v[3:0], v[3:0]};
   endfunction

   function automatic int bpp_of(input logic [2:0] code);
      case (code)
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 8;
         default: return 16;
      endcase
   endfunction

   function automatic logic [23:0] exp_pix(input logic [2:0] code, input bit tft,
                                           input logic [15:0] w, input int slot);
      int b;
      logic [15:0] ix;
      b = bpp_of(code);
      if (b < 16) begin
         ix = (w >> (slot * b)) & 16'((1 << b) - 1);
         return exp444(pal_m[ix[7:0]][11:0]);
      end
      if (tft) return {w[15:11], w[15:13], w[10:5], w[10:9], w[4:0], w[4:2]};
      return exp444(w[11:0]);
   endfunction

   task automatic pal_write(input int a, input logic [15:0] d);
      @(negedge clk);
      pal_we = 1'b1; pal_addr = 8'(a); pal_wdata = d;
      pal_m[a] = d;
      @(negedge clk);
      pal_we = 1'b0;
   endtask

   // runs one line and checks pixels, end marker, word count, stalls and latency
   task automatic run_line(input logic [2:0] code, input bit tft, input int width,
                           input int ready_mode, input bit poke, input int seed);
      int fi = 0, pc = 0, cyc = 0, done_at = -1, ppw, exp_words;
      bit active, stall = 0, prev_acc = 0, bad2 = 0;
      logic [23:0] s_rgb, e;
      logic s_eol;
      string req;
      active = (code != 0) && (width != 0);
      ppw = 16 / bpp_of(code);
      exp_words = (width * bpp_of(code) + 15) / 16;
      req = (bpp_of(code) < 16) ? "R3" : (tft ? "R4" : "R5");
      pal_write(0, {1'b0, code, pal_m[0][11:0]});
      @(negedge clk);
      tft_i = tft; width_i = 10'(width); line_start = 1'b1; word_valid = 1'b0;
      @(negedge clk);
      line_start = 1'b0;
      if (!active) done_at = 10;
      while (cyc < 4000) begin
         word_valid = 1'b1;
         word_data  = wordf(seed, fi);
         pix_ready  = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
         if (poke && cyc == 3) begin
            pal_we = 1'b1; pal_addr = 8'd0; pal_wdata = {4'b0, pal_m[0][11:0]};
            pal_m[0] = pal_wdata;
         end else begin
            pal_we = 1'b0;
         end
         #4;
         if (stall) begin
            // R8
            check(pix_valid && pix_rgb == s_rgb && pix_eol == s_eol, "R8", pix_rgb, s_rgb);
            stall = 0;
         end
         if (prev_acc) begin
            // R10
            check(pix_valid, "R10", pix_valid, 1);
            prev_acc = 0;
         end
         if (!active && (pix_valid || word_ready)) bad2 = 1;
         if (word_valid && word_ready) begin
            fi++;
            prev_acc = 1;
         end
         if (pix_valid && pix_ready) begin
            e = exp_pix(code, tft, wordf(seed, pc / ppw), pc % ppw);
            check(pix_rgb == e, req, pix_rgb, e);
            // R6
            check(pix_eol == (pc == width - 1), "R6", pix_eol, (pc == width - 1));
            pc++;
            if (pix_eol) done_at = cyc;
         end else if (pix_valid) begin
            stall = 1; s_rgb = pix_rgb; s_eol = pix_eol;
         end
         @(negedge clk);
         cyc++;
         if (done_at >= 0 && cyc >= done_at + 5) break;
      end
      pal_we = 1'b0; word_valid = 1'b0; pix_ready = 1'b0;
      if (active) begin
         // R6 pixel count, R7 word count
         check(pc == width, "R6", pc, width);
         check(fi == exp_words, "R7", fi, exp_words);
      end else begin
         // R2
         check(pc == 0 && fi == 0 && !bad2, "R2", pc + fi, 0);
      end
   endtask

   task automatic t_reset;
      #1;
      // R9
      check(!pix_valid && !word_ready, "R9", {pix_valid, word_ready}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #4;
      check(!pix_valid && !word_ready, "R9", {pix_valid, word_ready}, 0);
   endtask

   task automatic t_reset_code;
      // R9: entry 0 depth field is 0 after reset, so a line gives nothing
      @(negedge clk);
      width_i = 10'd4; line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      word_valid = 1'b1; pix_ready = 1'b1;
      #4;
      check(!pix_valid && !word_ready, "R9", {pix_valid, word_ready}, 0);
      @(negedge clk);
      word_valid = 1'b0; pix_ready = 1'b0;
   endtask

   task automatic t_fill_palette;
      for (int i = 1; i < 256; i++)
         pal_write(i, 16'((i * 16'h09E3) ^ 16'h05A5) & 16'h0fff);
   endtask

   task automatic t_depth2;       run_line(3'd1, 1'b0, 13, 0, 1'b0, 1); endtask // R1 R3 R7
   task automatic t_depth4;       run_line(3'd2, 1'b0, 10, 0, 1'b0, 2); endtask // R1 R3
   task automatic t_depth8_stall; run_line(3'd3, 1'b1, 7, 1, 1'b0, 3); endtask  // R1 R8
   task automatic t_tft565;       run_line(3'd6, 1'b1, 5, 0, 1'b0, 4); endtask  // R4
   task automatic t_stn444;       run_line(3'd7, 1'b0, 6, 1, 1'b0, 5); endtask  // R5
   task automatic t_long565;      run_line(3'd4, 1'b1, 300, 1, 1'b0, 6); endtask // R4 R6
   task automatic t_width1;       run_line(3'd1, 1'b0, 1, 0, 1'b0, 7); endtask  // R6 R7
   task automatic t_code0;        run_line(3'd0, 1'b1, 8, 0, 1'b0, 8); endtask  // R2
   task automatic t_width0;       run_line(3'd3, 1'b0, 0, 0, 1'b0, 9); endtask  // R2
   task automatic t_latch;        run_line(3'd2, 1'b0, 12, 1, 1'b1, 10); endtask // R1 mid-line write
   task automatic t_max2;         run_line(3'd1, 1'b0, 1023, 0, 1'b0, 11); endtask // R6 R7

   initial begin
      for (int i = 0; i < 256; i++) pal_m[i] = '0;
      t_reset;
      t_reset_code;
      t_fill_palette;
      t_depth2;
      t_depth4;
      t_depth8_stall;
      t_tft565;
      t_stn444;
      t_long565;
      t_width1;
      t_code0;
      t_width0;
      t_latch;
      t_max2;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule